// File: doc/BRIEF.md
# Scratchpad Write-Verify-Copy Memory Controller

This block is the memory-command layer of a small byte-addressed nonvolatile slave. A byte serializer hands it every byte the bus master sends (`wr_valid`/`wr_byte`). It also raises a request (`rd_req`) whenever the master opens a read slot for a byte. The controller answers each request one cycle later on `rd_valid`/`rd_byte`. It holds an 8-byte scratchpad, two target-address bytes (low byte TA1, high byte TA2) and a status byte. The status byte carries the ending offset, a partial-fill flag and a copy-accepted flag. The storage itself is a 144-byte register file: 128 data bytes in four 32-byte pages, then a 16-byte register row.

Writing is a two-step process. The master first fills the scratchpad with a write command and reads it back with a read command to confirm the contents. It then issues a copy command. The copy is accepted only if the master echoes TA1, TA2 and the status byte exactly. Per-page protection bytes decide how each incoming byte is loaded into the scratchpad: kept, masked, or taken as sent. A counter of `PROG_CYCLES` cycles stands in for the programming time of the array.

States:
- `ST_IDLE`: waits for a command byte.
- `ST_ADDR_LO` and `ST_ADDR_HI`: take the address for a write or a memory read.
- `ST_WS_DATA`: accepts scratchpad data.
- `ST_RS_HDR` and `ST_RS_DATA`: stream the scratchpad back.
- `ST_CRC_OUT`: sends a check word.
- `ST_RM_DATA`: streams the array.
- `ST_CP_AUTH`: collects the copy echo.
- `ST_CP_DONE`: after an accepted copy.
- `ST_DEAD`: the fill state.

Transitions:
- IDLE goes to ADDR_LO on `0Fh` or `F0h`, to RS_HDR on `AAh`, to CP_AUTH on `55h`, and to DEAD on any other byte.
- ADDR_LO goes to ADDR_HI.
- ADDR_HI goes to WS_DATA for a write command, otherwise to RM_DATA.
- WS_DATA goes to CRC_OUT when offset 7 is written.
- RS_HDR goes to RS_DATA after the third header read.
- RS_DATA goes to CRC_OUT after the ending offset is read.
- CRC_OUT goes to DEAD after two reads.
- CP_AUTH goes to CP_DONE or DEAD on the third echo byte.
- `bus_reset` returns any state to IDLE.

Top module: `spad_mem_ctrl`

## Requirements
- R1: Command byte `0Fh` selects scratchpad write, `AAh` scratchpad read, `55h` copy and `F0h` memory read. Scratchpad write and memory read then take the low address byte followed by the high byte. Any other command byte, and any read request in a state that sends nothing, returns `FFh`.
- R2: When the high address byte of a scratchpad write arrives, the partial flag is set, the accepted flag is cleared, and the ending offset and write pointer take address bits 2:0. Each data byte is stored at the pointer, the ending offset takes that pointer, and the pointer advances. Writing offset 7 clears the partial flag only when the start offset was 0.
- R3: The status byte has the accepted flag in bit 7, the partial flag in bit 5 and the ending offset in bits 2:0. Bits 6, 4 and 3 are always 0.
- R4: For a target address below 80h, the protection byte of its page sits at 80h plus the page number. The value 55h loads the stored array byte instead of the sent byte. The value AAh loads the bitwise AND of the sent byte and the stored byte. Any other value loads the sent byte.
- R5: A byte in 80h..84h that holds 55h or AAh is loaded into the scratchpad as its stored value, so a copy cannot change it.
- R6: A scratchpad read returns TA1, TA2 and the status byte, then the scratchpad bytes from the start offset through the ending offset. Next come the low and then the high byte of the inverted CRC-16 (x^16+x^15+x^2+1, reflected, initial value 0) over the command and every byte sent. After that it returns `FFh`. Each `rd_req` is answered by `rd_valid` in the next cycle.
- R7: A copy is accepted only if all of the following hold: the three echo bytes equal TA1, TA2 and the status byte; the address is below 90h; the partial flag is 0; and the copy is not blocked. When accepted, the accepted flag is set and all 8 scratchpad bytes are written to the row, and later reads return `AAh`. A refused copy returns `FFh`.
- R8: When the byte at 84h holds 55h or AAh, copies to the register row (80h and above) and to pages whose protection byte is 55h are refused.
- R9: A memory read streams array bytes from the given address up to 8Fh and `FFh` after that. It changes neither TA1, TA2, the status byte nor the scratchpad.
- R10: After a scratchpad write reaches offset 7, the next two reads return the low and then the high byte of the inverted CRC-16 over the command, TA1, TA2 and the data bytes as sent. Later reads return `FFh`.
- R11: After an accepted copy, `busy` is high for exactly `PROG_CYCLES` cycles. During that time written bytes are ignored and reads return `FFh`.
- R12: `bus_reset` returns the controller to `ST_IDLE` and keeps the scratchpad, TA1, TA2 and the status byte.
- R13: After `rst_n`:
  - every array byte is `FFh`;
  - TA1, TA2 and the status byte are 0;
  - `busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset | input | 1 | Bus reset pulse from the serializer; ends the current command |
| wr_valid | input | 1 | A byte from the master is present |
| wr_byte | input | 8 | Byte from the master |
| rd_req | input | 1 | The master opens a read slot for one byte |
| rd_valid | output | 1 | Response to the read request of the previous cycle |
| rd_byte | output | 8 | Byte returned to the master |
| busy | output | 1 | Array programming in progress |

## Verification
The bench builds the block with `PROG_CYCLES` = 16, so every accepted copy ends within a few dozen cycles. This lets a single run do all of the following:
- chain many copies;
- count the busy window exactly;
- push bytes into that window to check they are ignored.

The default row, page and array sizes are kept. This brings protection setup through the register row, page locking, masked loading, copy blocking and the read tail beyond 8Fh within reach of a reference model that tracks every byte of the array.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_WS_DATA,
        ST_RS_HDR,
        ST_RS_DATA,
        ST_CRC_OUT,
        ST_RM_DATA,
        ST_CP_AUTH,
        ST_CP_DONE,
        ST_DEAD
    } spm_state_t;

    typedef enum logic [1:0] {
        LD_OPEN,
        LD_KEEP,
        LD_AND
    } ld_mode_t;

    localparam logic [7:0] CMD_WR_SP  = 8'h0F;
    localparam logic [7:0] CMD_RD_SP  = 8'hAA;
    localparam logic [7:0] CMD_COPY   = 8'h55;
    localparam logic [7:0] CMD_RD_MEM = 8'hF0;
    localparam logic [7:0] LOCK_KEEP  = 8'h55;
    localparam logic [7:0] LOCK_AND   = 8'hAA;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] DONE_BYTE  = 8'hAA;

    function automatic logic lock_code(input logic [7:0] v);
        return (v == LOCK_KEEP) || (v == LOCK_AND);
    endfunction

endpackage

// File: rtl/spm_crc16.sv
module spm_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_q;
    logic [15:0] crc_d;

    always_comb begin
        crc_d = restart ? 16'h0000 : crc_q;
        for (int i = 0; i < 8; i++) begin
            if (crc_d[0] ^ din[i]) begin
                crc_d = (crc_d >> 1) ^ 16'hA001;
            end else begin
                crc_d = crc_d >> 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (step) begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/spm_array.sv
module spm_array
    import spm_pkg::*;
#(
    parameter int unsigned ROWS       = 18,
    parameter int unsigned DATA_ROWS  = 16,
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned ROW_BYTES  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              rd_addr,
    output logic [7:0]               rd_data,
    output ld_mode_t                 rd_mode,
    input  logic [15:0]              cp_addr,
    output logic                     cp_block,
    input  logic                     row_we,
    input  logic [ROW_BYTES*8-1:0]   row_data
);
    localparam int unsigned BYTES      = ROWS * ROW_BYTES;
    localparam int unsigned DATA_BYTES = DATA_ROWS * ROW_BYTES;
    localparam int unsigned PAGES      = DATA_BYTES / PAGE_BYTES;
    localparam int unsigned AW         = $clog2(BYTES);
    localparam int unsigned PW         = $clog2(PAGES);
    localparam int unsigned PB_W       = $clog2(PAGE_BYTES);
    localparam int unsigned OFF_W      = $clog2(ROW_BYTES);
    localparam int unsigned CP_IDX     = DATA_BYTES + PAGES;

    logic [7:0]       mem_q [BYTES];
    logic [PAGES-1:0] page_wp;
    logic [PAGES-1:0] page_ep;
    logic [AW-1:0]    row_base;
    logic             cp_lock;

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        assign page_wp[p] = (mem_q[DATA_BYTES + p] == LOCK_KEEP);
        assign page_ep[p] = (mem_q[DATA_BYTES + p] == LOCK_AND);
    end

    assign row_base = {cp_addr[AW-1:OFF_W], {OFF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= FILL_BYTE;
            end
        end else if (row_we) begin
            for (int b = 0; b < ROW_BYTES; b++) begin
                mem_q[row_base + AW'(b)] <= row_data[b*8 +: 8];
            end
        end
    end

    assign rd_data = (rd_addr < 16'(BYTES)) ? mem_q[rd_addr[AW-1:0]] : FILL_BYTE;

    always_comb begin
        rd_mode = LD_OPEN;
        if (rd_addr < 16'(DATA_BYTES)) begin
            if (page_wp[rd_addr[PB_W +: PW]]) begin
                rd_mode = LD_KEEP;
            end else if (page_ep[rd_addr[PB_W +: PW]]) begin
                rd_mode = LD_AND;
            end
        end else if (rd_addr <= 16'(CP_IDX) && lock_code(rd_data)) begin
            rd_mode = LD_KEEP;
        end
    end

    assign cp_lock  = lock_code(mem_q[CP_IDX]);
    assign cp_block = (cp_addr >= 16'(DATA_BYTES)) ? cp_lock
                                                   : (cp_lock && page_wp[cp_addr[PB_W +: PW]]);

    // A locked protection byte keeps its value through any copy of the register row
    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_we && cp_addr == 16'(DATA_BYTES) && lock_code(mem_q[DATA_BYTES]))
        |-> (row_data[7:0] == mem_q[DATA_BYTES]));

endmodule

// File: rtl/spad_mem_ctrl.sv
module spad_mem_ctrl
    import spm_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 2000,
    parameter int unsigned ROWS        = 18,
    parameter int unsigned DATA_ROWS   = 16,
    parameter int unsigned PAGE_BYTES  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [7:0] rd_byte,
    output logic       busy
);
    localparam int unsigned ROW_BYTES = 8;
    localparam int unsigned MEM_TOP   = ROWS * ROW_BYTES;
    localparam int unsigned CNT_W     = $clog2(PROG_CYCLES + 1);

    spm_state_t  state_q, state_d;
    logic [7:0]  cmd_q, lo_q, ta1_q, ta2_q;
    logic [2:0]  e_q, wp_q, off_q;
    logic        pf_q, aa_q;
    logic [1:0]  idx_q;
    logic [15:0] rm_q;
    logic [7:0]  auth0_q, auth1_q;
    logic [7:0]  sp_q [ROW_BYTES];
    logic [CNT_W-1:0] cnt_q;
    logic        rdv_q;
    logic [7:0]  rdb_q;

    logic        busy_w, byte_in, rd_take, copy_ok, row_we;
    logic [7:0]  es_w, out_byte, ld_byte, arr_data, crc_din;
    logic [15:0] tgt_w, arr_addr, crc_w;
    ld_mode_t    arr_mode;
    logic        cp_block, crc_restart, crc_step;
    logic [ROW_BYTES*8-1:0] row_data;

    assign busy_w  = (cnt_q != '0);
    assign byte_in = wr_valid && !busy_w && !bus_reset;
    assign rd_take = rd_req && !wr_valid && !busy_w && !bus_reset;
    assign es_w    = {aa_q, 1'b0, pf_q, 2'b00, e_q};
    assign tgt_w   = {ta2_q, ta1_q};
    assign arr_addr = (state_q == ST_RM_DATA) ? rm_q : {ta2_q, ta1_q[7:3], wp_q};

    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_row
        assign row_data[b*8 +: 8] = sp_q[b];
    end

    spm_array #(
        .ROWS(ROWS), .DATA_ROWS(DATA_ROWS), .PAGE_BYTES(PAGE_BYTES), .ROW_BYTES(ROW_BYTES)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(arr_addr), .rd_data(arr_data), .rd_mode(arr_mode),
        .cp_addr(tgt_w), .cp_block(cp_block),
        .row_we(row_we), .row_data(row_data)
    );

    assign crc_restart = byte_in && (state_q == ST_IDLE);
    assign crc_step    = (byte_in && (state_q == ST_IDLE || state_q == ST_WS_DATA ||
                         ((state_q == ST_ADDR_LO || state_q == ST_ADDR_HI) && cmd_q == CMD_WR_SP)))
                      || (rd_take && (state_q == ST_RS_HDR || state_q == ST_RS_DATA));
    assign crc_din     = byte_in ? wr_byte : out_byte;

    spm_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .restart(crc_restart), .step(crc_step),
        .din(crc_din), .crc(crc_w)
    );

    always_comb begin
        unique case (arr_mode)
            LD_KEEP: ld_byte = arr_data;
            LD_AND:  ld_byte = arr_data & wr_byte;
            default: ld_byte = wr_byte;
        endcase
    end

    assign copy_ok = (auth0_q == ta1_q) && (auth1_q == ta2_q) && (wr_byte == es_w)
                  && (tgt_w < 16'(MEM_TOP)) && !pf_q && !cp_block;
    assign row_we  = byte_in && (state_q == ST_CP_AUTH) && (idx_q == 2'd2) && copy_ok;

    always_comb begin
        unique case (state_q)
            ST_RS_HDR:  out_byte = (idx_q == 2'd0) ? ta1_q : (idx_q == 2'd1) ? ta2_q : es_w;
            ST_RS_DATA: out_byte = sp_q[off_q];
            ST_CRC_OUT: out_byte = (idx_q == 2'd0) ? ~crc_w[7:0] : ~crc_w[15:8];
            ST_RM_DATA: out_byte = (rm_q < 16'(MEM_TOP)) ? arr_data : FILL_BYTE;
            ST_CP_DONE: out_byte = DONE_BYTE;
            default:    out_byte = FILL_BYTE;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (byte_in) begin
                if (wr_byte == CMD_WR_SP || wr_byte == CMD_RD_MEM) state_d = ST_ADDR_LO;
                else if (wr_byte == CMD_RD_SP)                     state_d = ST_RS_HDR;
                else if (wr_byte == CMD_COPY)                      state_d = ST_CP_AUTH;
                else                                               state_d = ST_DEAD;
            end
            ST_ADDR_LO: if (byte_in) state_d = ST_ADDR_HI;
            ST_ADDR_HI: if (byte_in) state_d = (cmd_q == CMD_WR_SP) ? ST_WS_DATA : ST_RM_DATA;
            ST_WS_DATA: if (byte_in && wp_q == 3'd7) state_d = ST_CRC_OUT;
            ST_RS_HDR:  if (rd_take && idx_q == 2'd2) state_d = ST_RS_DATA;
            ST_RS_DATA: if (rd_take && off_q == e_q) state_d = ST_CRC_OUT;
            ST_CRC_OUT: if (rd_take && idx_q == 2'd1) state_d = ST_DEAD;
            ST_CP_AUTH: if (byte_in && idx_q == 2'd2) state_d = copy_ok ? ST_CP_DONE : ST_DEAD;
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0; lo_q <= '0; ta1_q <= '0; ta2_q <= '0;
            e_q <= '0; wp_q <= '0; off_q <= '0; pf_q <= 1'b0; aa_q <= 1'b0;
            idx_q <= '0; rm_q <= '0; auth0_q <= '0; auth1_q <= '0;
            cnt_q <= '0; rdv_q <= 1'b0; rdb_q <= FILL_BYTE;
            for (int i = 0; i < ROW_BYTES; i++) sp_q[i] <= '0;
        end else begin
            rdv_q <= rd_req;
            rdb_q <= busy_w ? FILL_BYTE : out_byte;

            if (bus_reset || state_d != state_q) begin
                idx_q <= '0;
            end else if ((rd_take && (state_q == ST_RS_HDR || state_q == ST_CRC_OUT))
                      || (byte_in && state_q == ST_CP_AUTH)) begin
                idx_q <= idx_q + 2'd1;
            end

            if (row_we) begin
                cnt_q <= CNT_W'(PROG_CYCLES);
            end else if (busy_w) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (byte_in) begin
                unique case (state_q)
                    ST_IDLE: begin
                        cmd_q <= wr_byte;
                        off_q <= ta1_q[2:0];
                    end
                    ST_ADDR_LO: lo_q <= wr_byte;
                    ST_ADDR_HI: begin
                        if (cmd_q == CMD_WR_SP) begin
                            ta1_q <= lo_q;
                            ta2_q <= wr_byte;
                            pf_q  <= 1'b1;
                            aa_q  <= 1'b0;
                            e_q   <= lo_q[2:0];
                            wp_q  <= lo_q[2:0];
                        end else begin
                            rm_q <= {wr_byte, lo_q};
                        end
                    end
                    ST_WS_DATA: begin
                        sp_q[wp_q] <= ld_byte;
                        e_q  <= wp_q;
                        wp_q <= wp_q + 3'd1;
                        if (wp_q == 3'd7 && ta1_q[2:0] == 3'd0) pf_q <= 1'b0;
                    end
                    ST_CP_AUTH: begin
                        if (idx_q == 2'd0) auth0_q <= wr_byte;
                        if (idx_q == 2'd1) auth1_q <= wr_byte;
                        if (row_we) aa_q <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (rd_take && state_q == ST_RS_DATA) off_q <= off_q + 3'd1;
            if (rd_take && state_q == ST_RM_DATA && rm_q < 16'(MEM_TOP)) rm_q <= rm_q + 16'd1;
        end
    end

    assign rd_valid = rdv_q;
    assign rd_byte  = rdb_q;
    assign busy     = busy_w;

    assert_ws_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_HI && cmd_q == CMD_WR_SP && byte_in)
        |=> (pf_q && !aa_q && e_q == $past(lo_q[2:0])));

    assert_rd_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_copy_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_w) |-> aa_q);

    assert_rm_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RM_DATA && rd_take)
        |=> ($stable(ta1_q) && $stable(ta2_q) && $stable(e_q) && $stable(pf_q)));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && wr_valid)
        |=> ($stable(ta1_q) && $stable(ta2_q) && $stable(e_q) && $stable(pf_q) && $stable(aa_q)));

endmodule

// File: tb/spad_mem_ctrl_bench.sv
`timescale 1ns/1ps
module spad_mem_ctrl_bench;
    localparam int PROG = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0;
    logic wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic rd_req = 1'b0;
    logic rd_valid;
    logic [7:0] rd_byte;
    logic busy;

    always #4 clk = ~clk;

    spad_mem_ctrl #(.PROG_CYCLES(PROG)) u_spad_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte), .busy(busy)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [7:0] m_mem [144];
    logic [7:0] m_sp [8];
    logic [7:0] m_ta1, m_ta2, m_cmd, m_lo;
    int         m_e, m_wp, m_mode, m_rm;
    bit         m_pf, m_aa, m_accept;
    logic [7:0] m_q [$];
    logic [7:0] m_crc [$];
    logic [7:0] m_auth [$];
    logic       pend_q = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_es();
        return {m_aa, 1'b0, m_pf, 2'b00, 3'(m_e)};
    endfunction

    function automatic bit locked(logic [7:0] v);
        return v == 8'h55 || v == 8'hAA;
    endfunction

    function automatic logic [15:0] crc16(logic [7:0] d [$]);
        logic [15:0] c = 16'h0;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ d[k][i]) c = (c >> 1) ^ 16'hA001;
                else c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic bit cp_blocked(int tgt);
        bit cpl = locked(m_mem[132]);
        if (tgt >= 128) return cpl;
        return cpl && (m_mem[128 + tgt / 32] == 8'h55);
    endfunction

    task automatic m_write(logic [7:0] b);
        int a;
        logic [7:0] old, v;
        logic [15:0] c;
        case (m_mode)
            0: begin
                m_cmd = b;
                m_crc = {b};
                if (b == 8'h0F || b == 8'hF0) m_mode = 1;
                else if (b == 8'hAA) begin
                    m_crc.push_back(m_ta1); m_crc.push_back(m_ta2); m_crc.push_back(m_es());
                    for (int i = int'(m_ta1[2:0]); i <= m_e; i++) m_crc.push_back(m_sp[i]);
                    c = crc16(m_crc);
                    m_q = m_crc;
                    void'(m_q.pop_front());
                    m_q.push_back(~c[7:0]); m_q.push_back(~c[15:8]);
                    m_mode = 4;
                end else if (b == 8'h55) begin
                    m_auth = {};
                    m_mode = 6;
                end else m_mode = 8;
            end
            1: begin m_lo = b; m_mode = 2; end
            2: begin
                if (m_cmd == 8'h0F) begin
                    m_ta1 = m_lo; m_ta2 = b; m_pf = 1; m_aa = 0;
                    m_e = int'(m_lo[2:0]); m_wp = m_e;
                    m_crc.push_back(m_lo); m_crc.push_back(b);
                    m_mode = 3;
                end else begin
                    m_rm = int'({b, m_lo});
                    m_mode = 5;
                end
            end
            3: begin
                a = int'({m_ta2, m_ta1[7:3], 3'(m_wp)});
                old = (a < 144) ? m_mem[a] : 8'hFF;
                v = b;
                if (a < 128) begin
                    if (m_mem[128 + a / 32] == 8'h55) v = old;
                    else if (m_mem[128 + a / 32] == 8'hAA) v = b & old;
                end else if (a <= 132 && locked(old)) v = old;
                m_sp[m_wp] = v;
                m_e = m_wp;
                m_crc.push_back(b);
                if (m_wp == 7) begin
                    if (m_ta1[2:0] == 3'd0) m_pf = 0;
                    c = crc16(m_crc);
                    m_q = {~c[7:0], ~c[15:8]};
                    m_mode = 4;
                end else m_wp++;
            end
            6: begin
                m_auth.push_back(b);
                if (m_auth.size() == 3) begin
                    a = int'({m_ta2, m_ta1});
                    m_accept = (m_auth[0] == m_ta1) && (m_auth[1] == m_ta2) && (m_auth[2] == m_es())
                             && a < 144 && !m_pf && !cp_blocked(a);
                    if (m_accept) begin
                        m_aa = 1;
                        for (int i = 0; i < 8; i++) m_mem[(a & ~7) + i] = m_sp[i];
                        m_mode = 7;
                    end else m_mode = 8;
                end
            end
            default: ;
        endcase
    endtask

    task automatic m_read(output logic [7:0] e);
        e = 8'hFF;
        if (m_mode == 4) begin
            if (m_q.size() > 0) e = m_q.pop_front();
        end else if (m_mode == 5) begin
            if (m_rm < 144) begin e = m_mem[m_rm]; m_rm++; end
        end else if (m_mode == 7) e = 8'hAA;
    endtask

    task automatic raw_send(logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_byte = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        raw_send(b);
        m_write(b);
    endtask

    task automatic get(string req);
        logic [7:0] e;
        m_read(e);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check(rd_valid && rd_byte == e, req, int'(rd_byte), int'(e));
    endtask

    task automatic breset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        m_mode = 0;
    endtask

    task automatic ws(logic [15:0] a, int n, logic [7:0] seed);
        breset();
        send(8'h0F); send(a[7:0]); send(a[15:8]);
        for (int i = 0; i < n; i++) send(seed + 8'(i * 17));
    endtask

    task automatic rs(string req);
        breset();
        send(8'hAA);
        for (int i = 0; i < 14; i++) get(req);
    endtask

    task automatic rm(logic [15:0] a, int n, string req);
        breset();
        send(8'hF0); send(a[7:0]); send(a[15:8]);
        for (int i = 0; i < n; i++) get(req);
    endtask

    task automatic copy_cur(string req);
        logic [7:0] t1, t2, es;
        t1 = m_ta1; t2 = m_ta2; es = m_es();
        breset();
        send(8'h55); send(t1); send(t2); send(es);
        if (m_accept) while (busy) @(negedge clk);
        get(req);
    endtask

    always @(posedge clk) pend_q <= rd_req;

    always @(negedge clk) begin
        if (rst_n && !done) check(rd_valid == pend_q, "R6", int'(rd_valid), int'(pend_q));
    end

    initial begin
        #(8ns * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 144; i++) m_mem[i] = 8'hFF;
        for (int i = 0; i < 8; i++) m_sp[i] = 8'h00;
        m_ta1 = 0; m_ta2 = 0; m_e = 0; m_pf = 0; m_aa = 0; m_mode = 0; m_accept = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R13", int'(busy), 0);
        check(rd_valid == 1'b0, "R13", int'(rd_valid), 0);
        get("R1");                       // idle read
        rm(16'h0000, 3, "R13");          // erased array
        rs("R13");                       // zero registers

        ws(16'h0010, 8, 8'hA0);          // full row, CRC tail
        get("R10"); get("R10"); get("R10");
        rs("R6");
        // R7 and R11: accepted copy, exact busy window
        breset();
        begin
            logic [7:0] t1, t2, es;
            t1 = m_ta1; t2 = m_ta2; es = m_es();
            send(8'h55); send(t1); send(t2); send(es);
        end
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == PROG, "R11", n, PROG);
        get("R7"); get("R7");
        rm(16'h000E, 12, "R9");
        rs("R3");                        // accepted flag now set

        ws(16'h0023, 2, 8'h31);          // partial fill at offset 3
        rs("R2");
        copy_cur("R7");                  // refused: partial
        rm(16'h0020, 6, "R7");

        ws(16'h0080, 0, 8'h00);          // protection setup
        send(8'h55); send(8'hAA); send(8'h00); send(8'h00);
        send(8'h00); send(8'h11); send(8'h22); send(8'h33);
        copy_cur("R7");
        ws(16'h0010, 8, 8'h00);          // page 0 locked
        rs("R4");
        ws(16'h0020, 8, 8'h0F);          // page 1 masked
        copy_cur("R4");
        ws(16'h0020, 8, 8'hF3);
        rs("R4");
        ws(16'h0080, 8, 8'h00);          // locked protection bytes
        rs("R5");

        ws(16'h0080, 0, 8'h00);          // set copy protection
        send(8'h00); send(8'h00); send(8'h00); send(8'h00);
        send(8'h55); send(8'h00); send(8'h00); send(8'h00);
        copy_cur("R8");
        ws(16'h0010, 8, 8'h5A);
        copy_cur("R8");                  // refused: locked page
        ws(16'h0040, 8, 8'h77);
        copy_cur("R8");                  // open page still allowed
        ws(16'h0080, 8, 8'h01);
        copy_cur("R8");                  // refused: register row
        rm(16'h0080, 8, "R8");

        // R11: bytes and reads during busy are ignored
        ws(16'h0048, 8, 8'h19);
        breset();
        begin
            logic [7:0] t1, t2, es;
            t1 = m_ta1; t2 = m_ta2; es = m_es();
            send(8'h55); send(t1); send(t2); send(es);
        end
        bus_reset = 1'b0;
        raw_send(8'h0F); raw_send(8'h49);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        check(rd_valid && rd_byte == 8'hFF, "R11", int'(rd_byte), 8'hFF);
        while (busy) @(negedge clk);
        get("R11");
        rs("R11");

        ws(16'h0061, 2, 8'h44);          // R12: bus reset mid write
        rs("R12");
        rm(16'h008E, 4, "R9");
        ws(16'h0090, 8, 8'h20);
        copy_cur("R7");                  // refused: beyond array
        breset();
        send(8'h33);
        get("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule